// File: doc/BRIEF.md
# Programmable Maximum Frame Length Checker

This block watches a byte stream in a MAC receive or transmit path and measures every frame that passes. Each accepted beat carries one byte. A start-of-frame marker opens a frame and an end-of-frame marker closes it. The block counts the bytes between the two markers and compares the total with a per-port programmable ceiling. The ceiling is a 14-bit value, so jumbo frames up to 16383 bytes are covered. A frame that carries a VLAN tag is allowed four more bytes. After reset the ceiling value is 1518. Writing 0x2667 selects the 9.6 KB jumbo operating point.

One cycle after the end-of-frame beat, the block presents the final length and an oversize verdict for that frame. It also gives a one-cycle increment strobe for the statistics bin that counts good frames from 1519 bytes up to the programmed ceiling. The block does not truncate data, check the CRC, or hold the statistics counters.

The input is a valid/ready stream. The block has no storage in the data path, so `in_ready` is low only while reset is applied and is high on every cycle after that. A beat is accepted on any clock edge where `in_valid` and `in_ready` are both high. An upstream source may hold `in_valid` low between beats at any time; idle cycles do not count. The result outputs are plain status pins and have no back-pressure.

Top module: `frame_len_checker`

## Requirements
- R1: While reset is applied, `in_ready`, `res_valid`, `res_oversize` and `res_bin_inc` are low. On the first clock edge after reset is released, `in_ready` goes high.
- R2: The length of a frame is the number of accepted beats from the start-of-frame beat through the end-of-frame beat, both included. Cycles with `in_valid` low are not counted. The length appears on `res_len`, with a one-cycle `res_valid` pulse, on the clock edge that follows the end-of-frame beat.
- R3: If `in_vlan` is high on any accepted beat of a frame, the frame's limit is the latched ceiling plus 4. Otherwise the limit is the latched ceiling. `res_oversize` is high exactly when the length is greater than this limit.
- R4: The ceiling is sampled from `max_size` on the start-of-frame beat. Changing `max_size` during a frame has no effect until the next start-of-frame.
- R5: `res_bin_inc` pulses together with `res_valid` only when all three conditions hold: the length is at least 1519, the frame is not oversize, and the latched ceiling is at least 1519. When the ceiling is below 1519, the strobe stays low even for a tagged frame that is accepted.
- R6: The byte count saturates at 2^CNT_W−1, which makes the frame oversize for every legal ceiling.
- R7: Beats accepted while no frame is open, and not marked start-of-frame, are ignored, even if they carry end-of-frame. A start-of-frame beat inside an open frame drops that frame without a result and begins a new frame.
- R8: A beat that carries both start-of-frame and end-of-frame is a complete frame of length 1.
- R9: The full ceiling range is honoured. With the ceiling at 0x3FFF, a 16383-byte untagged frame and a 16387-byte tagged frame are accepted, and a 16388-byte tagged frame is oversize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A stream beat (one byte) is offered |
| in_ready | output | 1 | The block accepts beats |
| in_sof | input | 1 | This beat opens a frame |
| in_eof | input | 1 | This beat closes a frame |
| in_vlan | input | 1 | The frame carries a VLAN tag (may be raised on any beat) |
| max_size | input | MAX_W (14) | Programmed ceiling on frame length in bytes |
| res_valid | output | 1 | One-cycle pulse: a frame has finished |
| res_len | output | CNT_W (17) | Final length of the last finished frame |
| res_oversize | output | 1 | The finished frame exceeded its limit |
| res_bin_inc | output | 1 | Increment for the 1519-to-ceiling size bin |

## Verification
The bench builds the block with a 15-bit byte counter instead of the default 17-bit one. This places the saturation point at 32767 bytes, which a single frame of about 33,000 beats can reach within the run, while the counter is still wider than the largest tagged limit of 16387. The 14-bit ceiling width and the 1518 default are kept. This lets the default, 9.6 KB jumbo and 0x3FFF ceilings, with and without the VLAN allowance, all be tested at their exact edges.

// File: rtl/flc_pkg.sv
package flc_pkg;

  // Whether a frame is currently open on the stream.
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_OPEN = 1'b1
  } frame_st_e;

  // Classification of one finished frame.
  typedef struct packed {
    logic over;
    logic bin;
  } verdict_t;

endpackage

// File: rtl/flc_byte_counter.sv
module flc_byte_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sof,
  input  logic             eof,
  output logic             start,
  output logic             take,
  output logic             last,
  output logic             open_now,
  output logic [CNT_W-1:0] len_now
);
  import flc_pkg::*;

  frame_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   inc;
  logic [CNT_W-1:0] sat;

  assign open_now = (st_q == FR_OPEN);
  assign start    = beat & sof;
  assign take     = beat & (sof | open_now);
  assign last     = take & eof;

  // Saturating increment of the running count.
  assign inc     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign sat     = inc[CNT_W] ? {CNT_W{1'b1}} : inc[CNT_W-1:0];
  assign len_now = start ? CNT_W'(1) : sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
    end else if (take) begin
      st_q  <= eof ? FR_IDLE : FR_OPEN;
      cnt_q <= len_now;
    end
  end

  // Within a frame the count never goes down; saturation holds it.
  assert_count_mono_R6: assert property (@(posedge clk) disable iff (rst)
    (open_now && beat && !sof) |=> (cnt_q >= $past(cnt_q)));

  assert_count_sat_R6: assert property (@(posedge clk) disable iff (rst)
    (open_now && beat && !sof && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == {CNT_W{1'b1}}));

  // Beats that fall outside any frame leave the state untouched.
  assert_stray_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!open_now && beat && !sof) |=> (st_q == FR_IDLE && $stable(cnt_q)));

endmodule

// File: rtl/flc_limit_latch.sv
module flc_limit_latch #(
  parameter int MAX_W    = 14,
  parameter int VLAN_ADD = 4,
  parameter int DEF_MAX  = 1518,
  localparam int EFF_W   = MAX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             take,
  input  logic             open_now,
  input  logic             vlan,
  input  logic [MAX_W-1:0] max_size,
  output logic [MAX_W-1:0] lim_now,
  output logic [EFF_W-1:0] eff_now
);

  logic [MAX_W-1:0] lim_q;
  logic             tag_q;
  logic             tag_now;

  assign lim_now = start ? max_size : lim_q;
  assign tag_now = start ? vlan : (tag_q | (take & vlan));
  assign eff_now = {1'b0, lim_now} + (tag_now ? EFF_W'(VLAN_ADD) : {EFF_W{1'b0}});

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= MAX_W'(DEF_MAX);
      tag_q <= 1'b0;
    end else if (take) begin
      lim_q <= lim_now;
      tag_q <= tag_now;
    end
  end

  // While a frame is open and no new one starts, the ceiling in use is frozen.
  assert_limit_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    (open_now && !start) |=> (open_now ? (lim_now == $past(lim_now) || start) : 1'b1));

  // Once seen, the tag allowance is not withdrawn before the frame ends.
  assert_tag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !start && tag_now && open_now) |=> (start || !open_now || tag_now));

endmodule

// File: rtl/flc_classify.sv
module flc_classify #(
  parameter int CNT_W   = 17,
  parameter int MAX_W   = 14,
  parameter int BIN_LOW = 1519,
  localparam int EFF_W  = MAX_W + 1,
  localparam int W      = CNT_W + 1
) (
  input  logic [CNT_W-1:0]  len,
  input  logic [EFF_W-1:0]  eff,
  input  logic [MAX_W-1:0]  lim,
  output flc_pkg::verdict_t vd
);

  localparam logic [W-1:0] BIN_C = W'(BIN_LOW);

  logic [W-1:0] len_x;
  logic [W-1:0] eff_x;
  logic [W-1:0] lim_x;

  assign len_x = W'(len);
  assign eff_x = W'(eff);
  assign lim_x = W'(lim);

  always_comb begin
    vd.over = (len_x > eff_x);
    vd.bin  = !vd.over && (len_x >= BIN_C) && (lim_x >= BIN_C);
  end

endmodule

// File: rtl/frame_len_checker.sv
module frame_len_checker #(
  parameter int MAX_W    = 14,
  parameter int CNT_W    = 17,
  parameter int VLAN_ADD = 4,
  parameter int BIN_LOW  = 1519,
  parameter int DEF_MAX  = 1518,
  localparam int EFF_W   = MAX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_vlan,
  input  logic [MAX_W-1:0] max_size,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_len,
  output logic             res_oversize,
  output logic             res_bin_inc
);
  import flc_pkg::*;

  logic             ready_q;
  logic             beat;
  logic             start;
  logic             take;
  logic             last;
  logic             open_now;
  logic [CNT_W-1:0] len_now;
  logic [MAX_W-1:0] lim_now;
  logic [EFF_W-1:0] eff_now;
  verdict_t         vd;

  assign in_ready = ready_q;
  assign beat     = in_valid & ready_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  flc_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .sof      (in_sof),
    .eof      (in_eof),
    .start    (start),
    .take     (take),
    .last     (last),
    .open_now (open_now),
    .len_now  (len_now)
  );

  flc_limit_latch #(
    .MAX_W    (MAX_W),
    .VLAN_ADD (VLAN_ADD),
    .DEF_MAX  (DEF_MAX)
  ) u_lim (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .take     (take),
    .open_now (open_now),
    .vlan     (in_vlan),
    .max_size (max_size),
    .lim_now  (lim_now),
    .eff_now  (eff_now)
  );

  flc_classify #(
    .CNT_W   (CNT_W),
    .MAX_W   (MAX_W),
    .BIN_LOW (BIN_LOW)
  ) u_cls (
    .len (len_now),
    .eff (eff_now),
    .lim (lim_now),
    .vd  (vd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      res_len      <= '0;
      res_oversize <= 1'b0;
      res_bin_inc  <= 1'b0;
    end else begin
      res_valid    <= last;
      res_oversize <= last & vd.over;
      res_bin_inc  <= last & vd.bin;
      if (last) res_len <= len_now;
    end
  end

  // A closing beat produces a result on the next edge, and only then.
  assert_result_after_eof_R2: assert property (@(posedge clk) disable iff (rst)
    last |=> res_valid);

  assert_result_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(last));

  // The bin strobe excludes oversize frames and short frames.
  assert_bin_good_only_R5: assert property (@(posedge clk) disable iff (rst)
    res_bin_inc |-> (res_valid && !res_oversize && res_len >= CNT_W'(BIN_LOW)));

  // A one-byte frame is never oversize.
  assert_single_ok_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_len == CNT_W'(1)) |-> !res_oversize);

  // Outputs are quiet during reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      assert_ready_low_in_reset_R1: assert (!in_ready || $past(!rst));
    end
  end

endmodule

// File: tb/frame_len_checker_bench.sv
module frame_len_checker_bench;

  localparam int MAX_W = 14;
  localparam int CNT_W = 15;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_sof = 1'b0;
  logic             in_eof = 1'b0;
  logic             in_vlan = 1'b0;
  logic [MAX_W-1:0] max_size = 14'd1518;
  logic             res_valid;
  logic [CNT_W-1:0] res_len;
  logic             res_oversize;
  logic             res_bin_inc;

  int n_chk = 0;
  int n_err = 0;

  logic             r_valid;
  int               r_len;
  logic             r_over;
  logic             r_bin;

  always #10 clk = ~clk;

  frame_len_checker #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_frame_len_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_sof       (in_sof),
    .in_eof       (in_eof),
    .in_vlan      (in_vlan),
    .max_size     (max_size),
    .res_valid    (res_valid),
    .res_len      (res_len),
    .res_oversize (res_oversize),
    .res_bin_inc  (res_bin_inc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
    in_vlan  = 1'b0;
  endtask

  // Sends one frame; optional idle gaps and a ceiling change at beat chg_at.
  task automatic run_frame(input int len, input bit vlan, input bit gaps,
                           input int chg_at, input int chg_val);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        idle();
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_vlan  = vlan;
      if (i == chg_at) max_size = MAX_W'(chg_val);
    end
    @(negedge clk);
    r_valid = res_valid;
    r_len   = int'(res_len);
    r_over  = res_oversize;
    r_bin   = res_bin_inc;
    idle();
  endtask

  task automatic expect_res(input string req, input int len, input bit over, input bit bin);
    chk(r_valid == 1'b1, req, r_valid, 1);
    chk(r_len == len, req, r_len, len);
    chk(r_over == over, req, r_over, over);
    chk(r_bin == bin, req, r_bin, bin);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready in reset", in_ready, 0);
    chk(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    chk(res_oversize == 1'b0 && res_bin_inc == 1'b0, "R1 flags in reset",
        res_oversize | res_bin_inc, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
  endtask

  task automatic t_default_edge();
    max_size = 14'd1518;
    run_frame(1518, 1'b0, 1'b0, -1, 0);
    expect_res("R3 default 1518 accepted", 1518, 1'b0, 1'b0);
    run_frame(1519, 1'b0, 1'b0, -1, 0);
    expect_res("R3 default 1519 oversize", 1519, 1'b1, 1'b0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R2 result is one-cycle pulse", res_valid, 0);
  endtask

  task automatic t_vlan_default();
    max_size = 14'd1518;
    run_frame(1522, 1'b1, 1'b0, -1, 0);
    expect_res("R5 tagged 1522 accepted no bin below 1519 ceiling", 1522, 1'b0, 1'b0);
    run_frame(1523, 1'b1, 1'b0, -1, 0);
    expect_res("R3 tagged 1523 oversize", 1523, 1'b1, 1'b0);
  endtask

  task automatic t_jumbo();
    max_size = 14'h2667;
    run_frame(1518, 1'b0, 1'b0, -1, 0);
    expect_res("R5 jumbo 1518 below bin", 1518, 1'b0, 1'b0);
    run_frame(1519, 1'b0, 1'b0, -1, 0);
    expect_res("R5 jumbo 1519 in bin", 1519, 1'b0, 1'b1);
    run_frame(9831, 1'b0, 1'b0, -1, 0);
    expect_res("R5 jumbo 9831 in bin", 9831, 1'b0, 1'b1);
    run_frame(9832, 1'b0, 1'b0, -1, 0);
    expect_res("R3 jumbo 9832 oversize", 9832, 1'b1, 1'b0);
  endtask

  task automatic t_full_range();
    max_size = 14'h3FFF;
    run_frame(16383, 1'b0, 1'b0, -1, 0);
    expect_res("R9 16383 accepted", 16383, 1'b0, 1'b1);
    run_frame(16387, 1'b1, 1'b0, -1, 0);
    expect_res("R9 tagged 16387 accepted", 16387, 1'b0, 1'b1);
    run_frame(16388, 1'b1, 1'b0, -1, 0);
    expect_res("R9 tagged 16388 oversize", 16388, 1'b1, 1'b0);
  endtask

  task automatic t_limit_change();
    max_size = 14'd1518;
    run_frame(2000, 1'b0, 1'b0, 10, 9831);
    expect_res("R4 mid-frame change ignored", 2000, 1'b1, 1'b0);
    run_frame(2000, 1'b0, 1'b0, -1, 0);
    expect_res("R4 new ceiling at next start", 2000, 1'b0, 1'b1);
  endtask

  task automatic t_saturate();
    max_size = 14'h3FFF;
    run_frame(33000, 1'b0, 1'b0, -1, 0);
    expect_res("R6 count saturates", 32767, 1'b1, 1'b0);
  endtask

  task automatic t_single_and_gaps();
    run_frame(1, 1'b0, 1'b0, -1, 0);
    expect_res("R8 one-beat frame", 1, 1'b0, 1'b0);
    run_frame(20, 1'b0, 1'b1, -1, 0);
    expect_res("R2 idle cycles not counted", 20, 1'b0, 1'b0);
  endtask

  task automatic t_stray_and_restart();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_eof   = (i == 2);
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 stray beats give no result", res_valid, 0);
    idle();
    run_frame(10, 1'b0, 1'b0, -1, 0);
    expect_res("R7 frame after stray beats", 10, 1'b0, 1'b0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
    end
    @(negedge clk);
    idle();
    chk(res_valid == 1'b0, "R7 open frame gives no result", res_valid, 0);
    run_frame(4, 1'b0, 1'b0, -1, 0);
    expect_res("R7 restart on new start", 4, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_default_edge();
    t_vlan_default();
    t_single_and_gaps();
    t_stray_and_restart();
    t_limit_change();
    t_jumbo();
    t_full_range();
    t_saturate();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule